// File: doc/BRIEF.md
# Operate Microinstruction Unit

This unit carries out the register-only "operate" class of instructions for a 12-bit accumulator machine. One instruction word holds several independent micro-operations, and any of them may be set together. The unit decodes that word and applies the selected operations to the accumulator and the one-bit link. It also raises a skip request or a halt request for the sequencer. The sequencer presents the instruction, the current accumulator, the current link and the operator switch word, then pulses `opEnable`. One clock later the unit shows the new accumulator and link values and a one-cycle skip or halt pulse.

The word is decoded as two groups. The first group clears, complements, increments and rotates. The second group tests skip conditions, ORs in the switch word and halts. Within a word the micro-operations run in a fixed order, so that combinations behave the same way every time. Memory access, fetch and program-counter handling are outside this block.

Instruction bit numbers below are LSB-first, so `instr[11]` is the most significant bit. An operate word has `instr[11:9] = 3'b111`.

Top module: `oprUnit`

## Requirements
- R1: If `opEnable` is high at a rising edge and `instr[11:9]` is 3'b111, the results of that word appear on `accOut` and `linkOut` after that edge. `skipReq` and `haltReq` are valid in the same cycle and stay high for one cycle only.
- R2: While `rst_n` is low, `accOut`, `linkOut`, `skipReq` and `haltReq` are all 0.
- R3: `instr[8]` selects the group: 0 selects group one and 1 selects group two. Group one never raises skip or halt. Group two always passes `linkIn` through to `linkOut` unchanged.
- R4: In group one, the clears run first: `instr[7]` clears the accumulator and `instr[6]` clears the link. The complements run next: `instr[5]` complements the accumulator and `instr[4]` complements the link.
- R5: In group one, `instr[0]` increments the accumulator modulo 4096 after the clears and complements. A carry out of the top bit complements the link.
- R6: In group one, rotation is the last step and acts on the 13-bit chain {link, accumulator}. `instr[3]` rotates right and `instr[2]` rotates left. `instr[1]` makes the rotation two places. If both `instr[3]` and `instr[2]` are set, or neither is, the chain does not rotate.
- R7: In group two, the skip conditions are: `instr[6]` selects accumulator negative (bit 11 set), `instr[5]` selects accumulator zero, and `instr[4]` selects link set. Without inversion, the unit skips if any selected condition holds. All conditions are tested on `accIn` before any clear or OR in the same word.
- R8: In group two, `instr[3]` inverts the sense of the test: the unit skips only if none of the selected conditions holds. With no condition selected and `instr[3]` set, the unit always skips.
- R9: In group two, `instr[7]` clears the accumulator first. `instr[2]` then ORs `switchIn` into the accumulator.
- R10: In group two, `instr[1]` raises `haltReq`.
- R11: If `opEnable` is low, or `instr[11:9]` is not 3'b111, then on the next cycle `accOut` and `linkOut` keep their previous values and `skipReq` and `haltReq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opEnable | input | 1 | Strobe: execute the presented word |
| instr | input | 12 | Instruction word |
| accIn | input | 12 | Current accumulator |
| linkIn | input | 1 | Current link |
| switchIn | input | 12 | Operator switch word |
| accOut | output | 12 | New accumulator |
| linkOut | output | 1 | New link |
| skipReq | output | 1 | One-cycle skip request |
| haltReq | output | 1 | One-cycle halt request |

## Verification
The bench targets the points where micro-operations interact, because each ordering mistake produces a specific wrong result:

- **Clear then complement:** a design that complements before clearing returns 0 instead of 7777 octal.
- **Increment then rotate:** a design that rotates before incrementing loses the carry that should have landed in the link.
- **Group-two skip test:** a design that tests the accumulator after clearing it skips on a zero-test word when it should not.
- **Conflicting rotate bits:** a design that gives one direction priority returns a rotated value when both direction bits are set.
- **Inverted test with no condition:** a design that gets this wrong fails to skip unconditionally.
- **Link carry and two-place rotation:** these cases expose an increment that drops the link carry and a two-place rotation that bypasses the link.

// File: rtl/oprPkg.sv
package oprPkg;
  localparam int INSTR_W = 12;
  localparam int OPC_W   = 3;
  localparam logic [OPC_W-1:0] OPC_OPERATE = 3'b111;

  // Bit positions in the instruction word (LSB-first).
  localparam int B_GROUP = 8;
  localparam int B_CLRA  = 7;
  localparam int B_G1CLL = 6;
  localparam int B_G1CMA = 5;
  localparam int B_G1CML = 4;
  localparam int B_G1RR  = 3;
  localparam int B_G1RL  = 2;
  localparam int B_G1TWO = 1;
  localparam int B_G1INC = 0;
  localparam int B_G2NEG = 6;
  localparam int B_G2ZER = 5;
  localparam int B_G2LNK = 4;
  localparam int B_G2INV = 3;
  localparam int B_G2OSR = 2;
  localparam int B_G2HLT = 1;

  typedef struct packed {
    logic load;
    logic group2;
    logic clrAcc;
    logic clrLink;
    logic cmpAcc;
    logic cmpLink;
    logic incAcc;
    logic rotLeft;
    logic rotRight;
    logic rotTwo;
    logic orSwitch;
    logic halt;
    logic testMinus;
    logic testZero;
    logic testLink;
    logic invert;
  } oprStrobes_t;
endpackage

// File: rtl/oprControl.sv
module oprControl
  import oprPkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opEnable,
  input  logic [INSTR_W-1:0] instr,
  output oprStrobes_t        strobes
);
  logic isOperate;
  logic isGroup2;
  logic rawLeft;
  logic rawRight;

  assign isOperate = opEnable && (instr[INSTR_W-1 -: OPC_W] == OPC_OPERATE);
  assign isGroup2  = instr[B_GROUP];
  assign rawLeft   = instr[B_G1RL];
  assign rawRight  = instr[B_G1RR];

  always_comb begin
    strobes = '0;
    strobes.load   = isOperate;
    strobes.group2 = isGroup2;
    strobes.clrAcc = instr[B_CLRA];
    if (!isGroup2) begin
      strobes.clrLink  = instr[B_G1CLL];
      strobes.cmpAcc   = instr[B_G1CMA];
      strobes.cmpLink  = instr[B_G1CML];
      strobes.incAcc   = instr[B_G1INC];
      // Opposing rotate bits cancel each other out.
      strobes.rotLeft  = rawLeft && !rawRight;
      strobes.rotRight = rawRight && !rawLeft;
      strobes.rotTwo   = instr[B_G1TWO];
    end else begin
      strobes.testMinus = instr[B_G2NEG];
      strobes.testZero  = instr[B_G2ZER];
      strobes.testLink  = instr[B_G2LNK];
      strobes.invert    = instr[B_G2INV];
      strobes.orSwitch  = instr[B_G2OSR];
      strobes.halt      = instr[B_G2HLT];
    end
  end

  AST_G1_NO_HALT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr[B_GROUP]) |-> !strobes.halt && !strobes.orSwitch && !strobes.invert); // R3
  AST_ROT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.rotLeft && strobes.rotRight)); // R6
endmodule

// File: rtl/oprDatapath.sv
module oprDatapath
  import oprPkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  oprStrobes_t       ctrl,
  input  logic [DATA_W-1:0] accIn,
  input  logic              linkIn,
  input  logic [DATA_W-1:0] switchIn,
  output logic [DATA_W-1:0] accOut,
  output logic              linkOut,
  output logic              skipReq,
  output logic              haltReq
);
  localparam int CHAIN_W = DATA_W + 1;

  logic [DATA_W-1:0]  g1Acc;
  logic               g1Link;
  logic [DATA_W-1:0]  g2Acc;
  logic               g2Skip;
  logic [DATA_W-1:0]  nextAcc;
  logic               nextLink;

  // Group one: clears, then complements, then increment, then rotation.
  always_comb begin
    logic [DATA_W-1:0]  a;
    logic               l;
    logic [DATA_W:0]    sum;
    logic [CHAIN_W-1:0] chain;
    a = accIn;
    l = linkIn;
    if (ctrl.clrAcc)  a = '0;
    if (ctrl.clrLink) l = 1'b0;
    if (ctrl.cmpAcc)  a = ~a;
    if (ctrl.cmpLink) l = ~l;
    sum = {1'b0, a} + {{DATA_W{1'b0}}, ctrl.incAcc};
    a = sum[DATA_W-1:0];
    if (sum[DATA_W]) l = ~l;
    chain = {l, a};
    if (ctrl.rotLeft) begin
      if (ctrl.rotTwo) chain = {chain[CHAIN_W-3:0], chain[CHAIN_W-1 -: 2]};
      else             chain = {chain[CHAIN_W-2:0], chain[CHAIN_W-1]};
    end else if (ctrl.rotRight) begin
      if (ctrl.rotTwo) chain = {chain[1:0], chain[CHAIN_W-1:2]};
      else             chain = {chain[0], chain[CHAIN_W-1:1]};
    end
    g1Acc  = chain[DATA_W-1:0];
    g1Link = chain[CHAIN_W-1];
  end

  // Group two: the tests read the incoming accumulator; clear, then OR switches.
  always_comb begin
    logic anyHit;
    anyHit = (ctrl.testMinus && accIn[DATA_W-1])
           | (ctrl.testZero  && (accIn == '0))
           | (ctrl.testLink  && linkIn);
    g2Skip = ctrl.invert ? !anyHit : anyHit;
    g2Acc  = ctrl.clrAcc ? '0 : accIn;
    if (ctrl.orSwitch) g2Acc = g2Acc | switchIn;
  end

  assign nextAcc  = ctrl.group2 ? g2Acc  : g1Acc;
  assign nextLink = ctrl.group2 ? linkIn : g1Link;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accOut  <= '0;
      linkOut <= 1'b0;
      skipReq <= 1'b0;
      haltReq <= 1'b0;
    end else begin
      skipReq <= ctrl.load && ctrl.group2 && g2Skip;
      haltReq <= ctrl.load && ctrl.group2 && ctrl.halt;
      if (ctrl.load) begin
        accOut  <= nextAcc;
        linkOut <= nextLink;
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.load |=> $stable(accOut) && $stable(linkOut) && !skipReq && !haltReq); // R11
  AST_G2_LINK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load && ctrl.group2 |=> linkOut == $past(linkIn)); // R3
  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load && ctrl.group2 && ctrl.halt |=> haltReq); // R10
  AST_UNCOND_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load && ctrl.group2 && ctrl.invert && !ctrl.testMinus && !ctrl.testZero
    && !ctrl.testLink |=> skipReq); // R8
  AST_G2_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.load && ctrl.group2 && ctrl.clrAcc && !ctrl.orSwitch |=> accOut == '0); // R9
  AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    skipReq |-> $past(ctrl.load && ctrl.group2)); // R1
endmodule

// File: rtl/oprUnit.sv
module oprUnit
  import oprPkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opEnable,
  input  logic [11:0]       instr,
  input  logic [DATA_W-1:0] accIn,
  input  logic              linkIn,
  input  logic [DATA_W-1:0] switchIn,
  output logic [DATA_W-1:0] accOut,
  output logic              linkOut,
  output logic              skipReq,
  output logic              haltReq
);
  oprStrobes_t strobes;

  oprControl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opEnable (opEnable),
    .instr    (instr),
    .strobes  (strobes)
  );

  oprDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (strobes),
    .accIn    (accIn),
    .linkIn   (linkIn),
    .switchIn (switchIn),
    .accOut   (accOut),
    .linkOut  (linkOut),
    .skipReq  (skipReq),
    .haltReq  (haltReq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !skipReq && !haltReq && accOut == '0 && !linkOut); // R2
endmodule

// File: tb/oprUnit_tb.sv
`timescale 1ns/100ps
module oprUnit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opEnable = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] accIn = '0;
  logic        linkIn = 1'b0;
  logic [11:0] switchIn = '0;
  logic [11:0] accOut;
  logic        linkOut;
  logic        skipReq;
  logic        haltReq;

  int checks = 0;
  int fails = 0;
  logic [11:0] expAcc = '0;
  logic        expLink = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  oprUnit u_dut (
    .clk(clk), .rst_n(rst_n), .opEnable(opEnable), .instr(instr),
    .accIn(accIn), .linkIn(linkIn), .switchIn(switchIn),
    .accOut(accOut), .linkOut(linkOut), .skipReq(skipReq), .haltReq(haltReq)
  );

  // Reference model: returns {halt, skip, link, acc}.
  function automatic logic [14:0] refModel(input logic [11:0] w, input logic [11:0] a,
                                           input logic l, input logic [11:0] sw);
    logic [12:0] c;
    logic sk;
    logic hit;
    if (w[8] == 1'b0) begin
      if (w[7]) a = 12'o0000;
      if (w[6]) l = 1'b0;
      if (w[5]) a = ~a;
      if (w[4]) l = ~l;
      if (w[0]) begin
        if (a == 12'o7777) l = ~l;
        a = a + 12'd1;
      end
      c = {l, a};
      if (w[2] && !w[3]) c = w[1] ? {c[10:0], c[12], c[11]} : {c[11:0], c[12]};
      if (w[3] && !w[2]) c = w[1] ? {c[1], c[0], c[12:2]} : {c[0], c[12:1]};
      return {1'b0, 1'b0, c};
    end
    hit = (w[6] && a[11]) || (w[5] && a == 12'o0000) || (w[4] && l);
    sk = w[3] ? !hit : hit;
    if (w[7]) a = 12'o0000;
    if (w[2]) a = a | sw;
    return {w[1], sk, l, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [11:0] got,
                     input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %o expected %o", req, what, got, exp);
    end
  endtask

  task automatic runOp(input string req, input logic en, input logic [11:0] w,
                       input logic [11:0] a, input logic l, input logic [11:0] sw);
    logic [14:0] r;
    logic isOp;
    @(negedge clk);
    opEnable = en; instr = w; accIn = a; linkIn = l; switchIn = sw;
    isOp = en && (w[11:9] == 3'b111);
    r = refModel(w, a, l, sw);
    @(negedge clk);
    opEnable = 1'b0;
    if (isOp) begin
      expAcc = r[11:0];
      expLink = r[12];
    end
    chk(req, "acc", accOut, expAcc);
    chk(req, "link", {11'd0, linkOut}, {11'd0, expLink});
    chk(req, "skip", {11'd0, skipReq}, {11'd0, isOp && r[13]});
    chk(req, "halt", {11'd0, haltReq}, {11'd0, isOp && r[14]});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2", "acc", accOut, 12'o0000);
    chk("R2", "flags", {9'd0, linkOut, skipReq, haltReq}, 12'd0);
    rst_n = 1'b1;

    // R4: clear both, then clear followed by complement
    runOp("R4", 1, 12'o7300, 12'o5555, 1, 0);
    chk("R4", "cla cll acc", accOut, 12'o0000);
    runOp("R4", 1, 12'o7240, 12'o1234, 0, 0);
    chk("R4", "cla cma", accOut, 12'o7777);
    runOp("R4", 1, 12'o7120, 12'o0001, 1, 0);
    // R5: increment with wrap and link carry
    runOp("R5", 1, 12'o7241, 12'o1234, 0, 0);
    chk("R5", "wrap link", {11'd0, linkOut}, 12'd1);
    runOp("R5", 1, 12'o7001, 12'o0017, 1, 0);
    // R6: rotations
    runOp("R6", 1, 12'o7004, 12'o4000, 0, 0);
    chk("R6", "ral acc", accOut, 12'o0000);
    runOp("R6", 1, 12'o7010, 12'o0001, 0, 0);
    runOp("R6", 1, 12'o7006, 12'o0001, 1, 0);
    chk("R6", "rtl acc", accOut, 12'o0006);
    runOp("R6", 1, 12'o7012, 12'o0003, 0, 0);
    chk("R6", "rtr acc", accOut, 12'o4000);
    runOp("R6", 1, 12'o7014, 12'o1234, 1, 0);
    chk("R6", "conflict acc", accOut, 12'o1234);
    runOp("R6", 1, 12'o7016, 12'o4321, 0, 0);
    runOp("R6", 1, 12'o7002, 12'o2222, 1, 0);
    runOp("R6", 1, 12'o7005, 12'o7777, 0, 0);
    chk("R6", "iac then ral", accOut, 12'o0001);
    // R3: group two keeps link; group one never skips
    runOp("R3", 1, 12'o7500, 12'o4000, 1, 0);
    runOp("R3", 1, 12'o7077, 12'o0000, 1, 0);
    // R7: skip tests
    runOp("R7", 1, 12'o7640, 12'o0000, 0, 0);
    runOp("R7", 1, 12'o7640, 12'o0001, 0, 0);
    chk("R7", "test before clear", {11'd0, skipReq}, 12'd0);
    runOp("R7", 1, 12'o7420, 12'o0000, 1, 0);
    runOp("R7", 1, 12'o7560, 12'o0005, 0, 0);
    // R8: inverted sense
    runOp("R8", 1, 12'o7510, 12'o4000, 0, 0);
    runOp("R8", 1, 12'o7430, 12'o0000, 1, 0);
    runOp("R8", 1, 12'o7450, 12'o0000, 0, 0);
    runOp("R8", 1, 12'o7410, 12'o0000, 0, 0);
    chk("R8", "skp", {11'd0, skipReq}, 12'd1);
    // R9: clear then OR switches
    runOp("R9", 1, 12'o7604, 12'o7777, 0, 12'o2525);
    chk("R9", "cla osr", accOut, 12'o2525);
    runOp("R9", 1, 12'o7404, 12'o0101, 0, 12'o1010);
    // R10: halt pulse lasts one cycle
    runOp("R10", 1, 12'o7402, 12'o0033, 1, 0);
    @(negedge clk);
    chk("R10", "halt drop", {11'd0, haltReq}, 12'd0);
    // R11: ignored words
    runOp("R11", 1, 12'o1234, 12'o7777, 1, 0);
    runOp("R11", 0, 12'o7402, 12'o5555, 0, 0);
    runOp("R11", 1, 12'o6402, 12'o0000, 0, 0);
    // R1: random operate words with one-cycle latency
    for (int i = 0; i < 400; i++) begin
      logic [11:0] w;
      w = {3'b111, 9'($urandom)};
      runOp("R1", ($urandom % 8) != 0, w, 12'($urandom), 1'($urandom), 12'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule